// File: doc/BRIEF.md
# Three-Phase Gate Control with Cycle-by-Cycle Current Limit

This block turns six PWM commands (one high-side and one low-side command per phase, three half-bridge phases) into six gate-enable outputs. Each phase follows a simple truth table. A phase whose two commands are both high is switched fully off. A phase whose commands swap directly from one side to the other is held off for a programmable dead time before the new gate turns on. The PWM commands pass through two-flop synchronizers, so a command change reaches the gates two clock edges after it is applied.

Three digital over-threshold flags, one per phase, drive a current-limit latch. Any flag switches off every gate in the same cycle and sets a status flag. The latch releases only after all flags are clear and the high-side commands of every phase that tripped have gone low, and then only on the next rising edge of any high-side command. There is no timer and no other re-arm. A hard-off input and two undervoltage inputs also switch off all gates. A two-bit override stands in for the externally driven limit pin: it can leave the limit function alone, force all gates off, or disable the limit function.

Top module: `tri_gate_ctrl`

## Requirements
- R1: Per phase, after synchronization (two clock edges), high=1/low=0 enables only the high-side gate, high=0/low=1 enables only the low-side gate, and high=0/low=0 enables neither.
- R2: A phase whose high and low commands are both 1 has both gates off.
- R3: When a phase's synchronized commands change directly from high-side to low-side conduction, or the reverse, both gates of that phase stay off for exactly DEAD_CYCLES cycles before the new gate turns on.
- R4: With the limit function enabled, any asserted over_thr bit switches all six gates off and sets ilim_flag in the same cycle. ilim_flag then stays set after over_thr clears.
- R5: A tripped limit releases only after two conditions hold: every over_thr bit is 0, and the synchronized high command of every phase that tripped is 0. The release then takes place at the next synchronized rising edge of any high command. The gates return one cycle after that edge.
- R6: With no rising edge on any high command, a tripped limit stays latched however long the trip conditions stay clear.
- R7: hard_off=1 switches all gates off in the same cycle, whatever the other inputs are.
- R8: ilim_ovr=1 (pin forced high) switches all gates off in the same cycle and does not by itself set ilim_flag.
- R9: ilim_ovr=2 (pin forced low) disables the limit function. over_thr is ignored, the latch clears, ilim_flag is 0, and the gates follow the PWM table. ilim_ovr=0 or 3 leaves the limit function active.
- R10: uv_a=1 or uv_bc=1 switches all gates off in the same cycle and has no effect on ilim_flag.
- R11: After synchronous reset, all gates are off, ilim_flag is 0 and no dead time is pending.
- R12: The high-side and low-side gates of a phase are never enabled together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_hi | input | 3 | High-side commands, bit 0 = phase A, bit 2 = phase C |
| pwm_lo | input | 3 | Low-side commands, same bit order |
| over_thr | input | 3 | Per-phase over-threshold flags from the current comparators |
| hard_off | input | 1 | Disables all gates while high |
| ilim_ovr | input | 2 | Limit-pin override: 0 none, 1 forced high, 2 forced low, 3 none |
| uv_a | input | 1 | Supply undervoltage for phase A |
| uv_bc | input | 1 | Supply undervoltage for phases B and C |
| gate_hi | output | 3 | High-side gate enables |
| gate_lo | output | 3 | Low-side gate enables |
| ilim_flag | output | 1 | Current limit tripped or latched |

## Verification
The release of the limit latch and the dead-time window of a swapping phase can both act on the same gate in the same cycle. So can a fresh trip and a rising high-side edge that would otherwise release the latch. The bench provokes these cases with a directed trip/re-arm sequence and with a long stretch of random commands in which over-threshold pulses, swaps and edges collide. A behavioural reference model judges every cycle: its queue-based synchronizer and per-phase countdowns decide which gates should be on. Dead-time length and the 100%-duty lockup are also measured directly at the ports.

// File: rtl/tgc_pkg.sv
package tgc_pkg;

  typedef enum logic [1:0] {
    PH_OFF = 2'd0,
    PH_TOP = 2'd1,
    PH_BOT = 2'd2
  } ph_mode_e;

  typedef enum logic [1:0] {
    OVR_NONE = 2'd0,
    OVR_HIGH = 2'd1,
    OVR_LOW  = 2'd2,
    OVR_RSVD = 2'd3
  } ovr_e;

  // Truth table of one half bridge: conflicting or idle commands give OFF.
  function automatic ph_mode_e cmd_to_mode(input logic hi, input logic lo);
    case ({hi, lo})
      2'b10:   return PH_TOP;
      2'b01:   return PH_BOT;
      default: return PH_OFF;
    endcase
  endfunction

  // Direct hand-over from one conducting side to the other.
  function automatic logic is_swap(input ph_mode_e prev, input ph_mode_e cur);
    return (cur != PH_OFF) && (prev != PH_OFF) && (cur != prev);
  endfunction

endpackage

// File: rtl/tgc_sync.sv
module tgc_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/tgc_deadband.sv
module tgc_deadband
  import tgc_pkg::*;
#(
  parameter int DEAD_CYCLES = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  ph_mode_e mode_i,
  output ph_mode_e mode_o
);
  localparam int CW = $clog2(DEAD_CYCLES + 1);

  ph_mode_e        prev_q;
  logic [CW-1:0]   cnt_q;
  logic            swap;

  assign swap   = is_swap(prev_q, mode_i);
  assign mode_o = (swap || cnt_q != '0) ? PH_OFF : mode_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= PH_OFF;
      cnt_q  <= '0;
    end else begin
      prev_q <= mode_i;
      if (swap)
        cnt_q <= CW'(DEAD_CYCLES - 1);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tgc_limit.sv
module tgc_limit #(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           lim_en,
  input  logic [NPH-1:0] over,
  input  logic [NPH-1:0] top_s,
  input  logic [NPH-1:0] top_rise,
  output logic           flag,
  output logic           release_evt
);
  logic           latch_q, armed_q;
  logic [NPH-1:0] who_q;
  logic           any_over, cond_now;

  assign any_over    = |over;
  assign cond_now    = !any_over && ((who_q & top_s) == '0);
  assign release_evt = lim_en && latch_q && !any_over && (armed_q || cond_now) && (|top_rise);
  assign flag        = lim_en && (latch_q || any_over);

  always_ff @(posedge clk) begin
    if (rst || !lim_en) begin
      latch_q <= 1'b0;
      armed_q <= 1'b0;
      who_q   <= '0;
    end else if (any_over) begin
      latch_q <= 1'b1;
      armed_q <= 1'b0;
      who_q   <= latch_q ? (who_q | over) : over;
    end else if (release_evt) begin
      latch_q <= 1'b0;
      armed_q <= 1'b0;
      who_q   <= '0;
    end else if (latch_q && cond_now) begin
      armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tri_gate_ctrl.sv
module tri_gate_ctrl
  import tgc_pkg::*;
#(
  parameter int DEAD_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] pwm_hi,
  input  logic [2:0] pwm_lo,
  input  logic [2:0] over_thr,
  input  logic       hard_off,
  input  logic [1:0] ilim_ovr,
  input  logic       uv_a,
  input  logic       uv_bc,
  output logic [2:0] gate_hi,
  output logic [2:0] gate_lo,
  output logic       ilim_flag
);
  localparam int NPH = 3;

  logic [2*NPH-1:0] cmd_s;
  logic [NPH-1:0]   top_s, bot_s, top_prev, top_rise;
  logic             lim_en, gates_en, release_evt;

  tgc_sync #(.W(2*NPH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({pwm_hi, pwm_lo}),
    .q   (cmd_s)
  );

  assign top_s = cmd_s[2*NPH-1:NPH];
  assign bot_s = cmd_s[NPH-1:0];

  always_ff @(posedge clk) begin
    if (rst) top_prev <= '0;
    else     top_prev <= top_s;
  end
  assign top_rise = top_s & ~top_prev;

  assign lim_en = (ilim_ovr != OVR_LOW);

  tgc_limit #(.NPH(NPH)) u_limit (
    .clk         (clk),
    .rst         (rst),
    .lim_en      (lim_en),
    .over        (over_thr),
    .top_s       (top_s),
    .top_rise    (top_rise),
    .flag        (ilim_flag),
    .release_evt (release_evt)
  );

  assign gates_en = !hard_off && !uv_a && !uv_bc && (ilim_ovr != OVR_HIGH) && !ilim_flag;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    ph_mode_e want, allowed;
    assign want = cmd_to_mode(top_s[p], bot_s[p]);

    tgc_deadband #(.DEAD_CYCLES(DEAD_CYCLES)) u_db (
      .clk    (clk),
      .rst    (rst),
      .mode_i (want),
      .mode_o (allowed)
    );

    assign gate_hi[p] = gates_en && (allowed == PH_TOP);
    assign gate_lo[p] = gates_en && (allowed == PH_BOT);
  end
endmodule

// File: rtl/tri_gate_ctrl_chk.sv
module tri_gate_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] over_thr,
  input logic       hard_off,
  input logic [1:0] ilim_ovr,
  input logic       uv_a,
  input logic       uv_bc,
  input logic [2:0] gate_hi,
  input logic [2:0] gate_lo,
  input logic       ilim_flag,
  input logic       release_evt
);
  assert_no_shoot_R12: assert property (@(posedge clk) disable iff (rst)
    (gate_hi & gate_lo) == 3'b000);

  assert_hard_off_R7: assert property (@(posedge clk) disable iff (rst)
    hard_off |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

  assert_undervolt_R10: assert property (@(posedge clk) disable iff (rst)
    (uv_a || uv_bc) |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

  assert_trip_R4: assert property (@(posedge clk) disable iff (rst)
    (ilim_ovr != 2'd2 && over_thr != 3'b000) |->
      (ilim_flag && gate_hi == 3'b000 && gate_lo == 3'b000));

  assert_force_high_R8: assert property (@(posedge clk) disable iff (rst)
    (ilim_ovr == 2'd1) |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

  assert_force_low_R9: assert property (@(posedge clk) disable iff (rst)
    (ilim_ovr == 2'd2) |-> !ilim_flag);

  assert_release_edge_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $fell(ilim_flag) && ilim_ovr != 2'd2 && $past(ilim_ovr) != 2'd2)
      |-> $past(release_evt));
endmodule

bind tri_gate_ctrl tri_gate_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .over_thr    (over_thr),
  .hard_off    (hard_off),
  .ilim_ovr    (ilim_ovr),
  .uv_a        (uv_a),
  .uv_bc       (uv_bc),
  .gate_hi     (gate_hi),
  .gate_lo     (gate_lo),
  .ilim_flag   (ilim_flag),
  .release_evt (release_evt)
);

// File: tb/tri_gate_ctrl_test.sv
module tri_gate_ctrl_test;
  localparam int DC = 8;

  logic       clk = 1'b0, rst = 1'b1;
  logic [2:0] hi = '0, lo = '0, ov = '0;
  logic       hoff = 1'b0, uva = 1'b0, uvb = 1'b0;
  logic [1:0] fo = 2'd0;
  wire  [2:0] ghi, glo;
  wire        flg;

  int n_chk = 0, n_bad = 0;
  bit started = 0, done = 0;

  always #10 clk = ~clk;

  tri_gate_ctrl #(.DEAD_CYCLES(DC)) uut (
    .clk(clk), .rst(rst), .pwm_hi(hi), .pwm_lo(lo), .over_thr(ov),
    .hard_off(hoff), .ilim_ovr(fo), .uv_a(uva), .uv_bc(uvb),
    .gate_hi(ghi), .gate_lo(glo), .ilim_flag(flg)
  );

  // ---------------- reference model ----------------
  bit [5:0] hq[$];          // delayed {hi,lo}; hq[0] is what the gates see
  bit [2:0] m_tprev, m_who;
  bit       m_lat, m_arm;
  int       m_pm[3], m_dl[3];

  function automatic int mode_of(bit t, bit b);
    if (t && !b) return 1;
    if (!t && b) return 2;
    return 0;
  endfunction

  task automatic model_out(output bit [2:0] eh, output bit [2:0] el, output bit ef);
    bit [5:0] s;
    bit en;
    s  = hq[0];
    ef = (fo != 2'd2) && (m_lat || ov != 3'b000);
    en = !hoff && !uva && !uvb && fo != 2'd1 && !ef;
    for (int p = 0; p < 3; p++) begin
      int w;
      bit sw, ok;
      w  = mode_of(s[3+p], s[p]);
      sw = (w != 0) && (m_pm[p] != 0) && (w != m_pm[p]);
      ok = en && !sw && (m_dl[p] == 0);
      eh[p] = ok && (w == 1);
      el[p] = ok && (w == 2);
    end
  endtask

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      hq = {6'd0, 6'd0};
      m_tprev = 0; m_who = 0; m_lat = 0; m_arm = 0;
      for (int p = 0; p < 3; p++) begin m_pm[p] = 0; m_dl[p] = 0; end
    end else begin
      bit [2:0] tops, rise;
      bit cond, anyo;
      tops = hq[0][5:3];
      rise = tops & ~m_tprev;
      for (int p = 0; p < 3; p++) begin
        int w;
        w = mode_of(hq[0][3+p], hq[0][p]);
        if (w != 0 && m_pm[p] != 0 && w != m_pm[p]) m_dl[p] = DC - 1;
        else if (m_dl[p] > 0) m_dl[p]--;
        m_pm[p] = w;
      end
      anyo = (ov != 3'b000);
      cond = !anyo && ((m_who & tops) == 3'b000);
      if (fo == 2'd2) begin
        m_lat = 0; m_arm = 0; m_who = 0;
      end else if (anyo) begin
        m_who = m_lat ? (m_who | ov) : ov;
        m_lat = 1; m_arm = 0;
      end else if (m_lat && (m_arm || cond) && rise != 3'b000) begin
        m_lat = 0; m_arm = 0; m_who = 0;
      end else if (m_lat && cond) begin
        m_arm = 1;
      end
      m_tprev = tops;
      hq.push_back({hi, lo});
      void'(hq.pop_front());
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #5;
    if (started && !done) begin
      bit [2:0] eh, el;
      bit ef;
      string tag;
      model_out(eh, el, ef);
      if (rst)                  tag = "R11";
      else if (uva || uvb)      tag = "R10";
      else if (hoff)            tag = "R7";
      else if (fo == 2'd1)      tag = "R8";
      else if (fo == 2'd2)      tag = "R9";
      else if (ef || m_lat)     tag = "R4";
      else                      tag = "R1";
      n_chk++;
      if (ghi !== eh || glo !== el || flg !== ef) begin
        n_bad++;
        $display("FAIL %s cycle compare: actual hi=%b lo=%b flag=%b expected hi=%b lo=%b flag=%b",
                 tag, ghi, glo, flg, eh, el, ef);
      end
      n_chk++;
      if ((ghi & glo) !== 3'b000) begin
        n_bad++;
        $display("FAIL R12 overlap: actual %b expected 000", ghi & glo);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 190000);
    n_bad++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    wait_cyc(3);
    rst = 1'b0;
    #5;
    check(ghi == 0 && glo == 0 && flg == 0, "R11 reset state", {ghi, glo, flg}, 0);

    // R1 truth table: A high side, B low side, C idle
    @(negedge clk); hi = 3'b001; lo = 3'b010;
    wait_cyc(3); #5;
    check(ghi == 3'b001 && glo == 3'b010, "R1 table", {ghi, glo}, 6'b001010);

    // R2 both commands high on phase C
    @(negedge clk); hi = 3'b101; lo = 3'b110;
    wait_cyc(DC + 4); #5;
    check(ghi[2] == 0 && glo[2] == 0, "R2 both high", {ghi[2], glo[2]}, 0);

    // R3 dead time on a direct swap of phase A
    @(negedge clk); hi = 3'b001; lo = 3'b000;
    wait_cyc(DC + 4);
    @(negedge clk); hi = 3'b000; lo = 3'b001;
    cnt = 0;
    for (int i = 0; i < DC + 10; i++) begin
      @(negedge clk); #5;
      if (ghi[0] == 0 && glo[0] == 0) cnt++;
      if (glo[0]) break;
    end
    check(cnt == DC && glo[0] == 1, "R3 dead cycles", cnt, DC);

    // R4 trip, R6 lock without edges, R5 re-arm rules
    @(negedge clk); hi = 3'b001; lo = 3'b000;
    wait_cyc(DC + 4);
    @(negedge clk); ov = 3'b001; #5;
    check(flg == 1 && ghi == 0 && glo == 0, "R4 trip", {flg, ghi, glo}, 7'b1000000);
    @(negedge clk); ov = 3'b000;
    wait_cyc(20); #5;
    check(flg == 1 && ghi == 0, "R6 held at 100% duty", flg, 1);
    @(negedge clk); hi = 3'b011;          // B rises, but A (offender) still high
    wait_cyc(4); #5;
    check(flg == 1, "R5 no release while offender high", flg, 1);
    @(negedge clk); hi = 3'b010;          // A low, no new rising edge
    wait_cyc(4); #5;
    check(flg == 1, "R5 needs a rising edge", flg, 1);
    @(negedge clk); hi = 3'b110;          // C rises
    wait_cyc(4); #5;
    check(flg == 0 && ghi == 3'b110, "R5 release", {flg, ghi}, 4'b0110);

    // R7 hard disable
    @(negedge clk); hoff = 1'b1; #5;
    check(ghi == 0 && glo == 0, "R7 hard off", {ghi, glo}, 0);
    @(negedge clk); hoff = 1'b0;

    // R8 pin forced high
    @(negedge clk); fo = 2'd1; #5;
    check(ghi == 0 && flg == 0, "R8 forced high", {ghi, flg}, 0);
    @(negedge clk); fo = 2'd0;

    // R9 pin forced low: limit ignored
    @(negedge clk); fo = 2'd2; ov = 3'b111; #5;
    check(flg == 0 && ghi == 3'b110, "R9 forced low", {flg, ghi}, 4'b0110);
    @(negedge clk); ov = 3'b000; fo = 2'd0;

    // R10 undervoltage on either supply
    @(negedge clk); uva = 1'b1; #5;
    check(ghi == 0 && flg == 0, "R10 uv phase A", {ghi, flg}, 0);
    @(negedge clk); uva = 1'b0; uvb = 1'b1; #5;
    check(ghi == 0 && flg == 0, "R10 uv phases B/C", {ghi, flg}, 0);
    @(negedge clk); uvb = 1'b0;

    // random stretch, judged by the model every cycle
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 5) == 0) hi = 3'($urandom);
      if ($urandom_range(0, 5) == 0) lo = 3'($urandom);
      ov   = ($urandom_range(0, 30) == 0) ? 3'($urandom) : 3'b000;
      hoff = ($urandom_range(0, 60) == 0);
      uva  = ($urandom_range(0, 80) == 0);
      uvb  = ($urandom_range(0, 80) == 0);
      if ($urandom_range(0, 100) == 0) fo = 2'($urandom);
      else if ($urandom_range(0, 10) == 0) fo = 2'd0;
    end

    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule